// File: doc/BRIEF.md
# SD Host Command and Status Register Unit

This block is the software-facing register file of a simple SD host controller. A processor reaches it over a 16-bit register bus. Through that bus it sets a 32-bit command argument, writes a command word that starts a command, reads back a 32-bit card response, and manages a 32-bit interrupt status word and its matching interrupt mask. Each 32-bit register is split into two 16-bit halves. The low half sits at the base offset and the high half at base + 2. Only even byte addresses decode.

The card side is modelled by an event port. `evt_flags` carries one-cycle pulses whose bit positions match the status word, and `evt_resp` carries the response value that goes with a response-end pulse. Status bits are sticky. Software clears a bit by writing 0 to it; writing 1 leaves the bit unchanged.

A four-state controller tracks the command:

- **IDLE**: no command is running. A write to the command register moves the controller to ISSUE.
- **ISSUE**: lasts one cycle and raises `cmd_start`. An error event in this cycle returns the controller to IDLE. Otherwise it moves to WAIT_RESP.
- **WAIT_RESP**: waits for the card to answer. A response-end event moves the controller to WAIT_DATA if the command word's data flag is set, and to IDLE if it is not. Any error event returns it to IDLE.
- **WAIT_DATA**: waits for the data phase to finish. A data-end event or any error event returns the controller to IDLE.

While the controller is in any state other than IDLE, status bit 30 reads as 1. During that time, changes to the clock control and option registers are refused.

Top module: `sdh_regs`

## Requirements
- R1: After reset the status word reads 0, the mask reads 0xFFFF_FFFF, `irq` is 0, the clock control register reads 0, and `card_clk_en` is 0.
- R2: A write to byte offset 0x00 while idle latches the command word onto `cmd_word` and raises `cmd_start` for exactly one cycle, starting the cycle after the write edge. The command word is laid out as follows: index in bits 5:0, response type in bits 10:8 (3 none, 4 R1/R6, 5 R1b, 6 R2, 7 R3), data-phase flag in bit 11, read flag in bit 12.
- R3: Status bit 30 reads 1 from the start of a command until one of the following: a response-end event (status bit 0) when the data flag is clear; a data-end event (status bit 2) after the response when the data flag is set; or any error event, whichever comes first.
- R4: A write to the command register while status bit 30 is 1 is ignored. `cmd_word` keeps its value and no new `cmd_start` pulse appears.
- R5: An event pulse sets, and holds, the status bits it carries, but only these positions: 0 (response end), 2 (data end), 24 (read data ready), and the error bits 16 to 22, 29 and 31. All other stored positions read 0.
- R6: A write to the status low half (0x1C) or high half (0x1E) clears each bit written as 0 and leaves each bit written as 1 unchanged. The other half is not affected.
- R7: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when some latched status bit is set and its mask bit (mask at 0x20/0x22) is 0.
- R9: The argument register at 0x04 (low half) and 0x06 (high half) reads back what was written and drives `cmd_arg`.
- R10: On a response-end event, `evt_resp` is captured into the response register. That register reads at 0x0C (low half) and 0x0E (high half).
- R11: Writes to clock control (0x24) and option (0x28) are refused while status bit 30 is 1. In clock control, bit 8 drives `card_clk_en` and bit 6 drives `card_clk_slow` (the divide-by-256 init rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 8 | Byte address, even offsets only |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| evt_flags | input | 32 | Card-side event pulses, positions as in the status word |
| evt_resp | input | 32 | Response value captured with a response-end pulse |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_word | output | 16 | Latched command word |
| cmd_arg | output | 32 | Command argument |
| card_clk_en | output | 1 | Card clock enable |
| card_clk_slow | output | 1 | Slow initialisation clock select |
| xfer_len | output | 16 | Transfer length register (0x26) |
| card_opt | output | 16 | Option register (0x28) |
| irq | output | 1 | Interrupt request |

## Verification
A controller state that is wrong shows up one cycle later at status bit 30 and at `cmd_start`. Two cases matter most. A controller stuck in WAIT_RESP or WAIT_DATA holds bit 30 high, and the next command write is then swallowed. A controller that leaves the busy states too early drops bit 30 before data end, and the clock register then accepts a write it should refuse. A wrong keep/clear merge in the status word is visible on the first readback after the write edge, and on `irq` in that same cycle.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFS_CMD    = 8'h00;
    localparam logic [7:0] OFS_ARG    = 8'h04;
    localparam logic [7:0] OFS_RSP    = 8'h0C;
    localparam logic [7:0] OFS_STS    = 8'h1C;
    localparam logic [7:0] OFS_MSK    = 8'h20;
    localparam logic [7:0] OFS_CLKCTL = 8'h24;
    localparam logic [7:0] OFS_LEN    = 8'h26;
    localparam logic [7:0] OFS_OPT    = 8'h28;

    localparam int BIT_RESP_END = 0;
    localparam int BIT_DATA_END = 2;
    localparam int BIT_BUSY     = 30;
    localparam int CMD_DATA_BIT = 11;
    localparam int CLK_EN_BIT   = 8;
    localparam int CLK_SLOW_BIT = 6;

    localparam logic [WORD_W-1:0] ERR_BITS  = 32'hA07F_0000;
    localparam logic [WORD_W-1:0] DONE_BITS = 32'h0100_0005;
    localparam logic [WORD_W-1:0] IMPL_BITS = ERR_BITS | DONE_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RESP,
        ST_WAIT_DATA
    } cmd_state_t;
endpackage

// File: rtl/sdh_cmd_fsm.sv
module sdh_cmd_fsm
    import sdh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic data_phase,
    input  logic resp_end,
    input  logic data_end,
    input  logic error_evt,
    output logic busy,
    output logic cmd_start
);
    cmd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_req) state_d = ST_ISSUE;
            ST_ISSUE:     state_d = error_evt ? ST_IDLE : ST_WAIT_RESP;
            ST_WAIT_RESP: begin
                if (error_evt)     state_d = ST_IDLE;
                else if (resp_end) state_d = data_phase ? ST_WAIT_DATA : ST_IDLE;
            end
            ST_WAIT_DATA: if (error_evt || data_end) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        cmd_start = (state_q == ST_ISSUE);
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);
    assert_busy_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(resp_end || data_end || error_evt));
endmodule

// File: rtl/sdh_status_unit.sv
module sdh_status_unit
    import sdh_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL_MASK = IMPL_BITS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sts_wr_lo,
    input  logic              sts_wr_hi,
    input  logic              msk_wr_lo,
    input  logic              msk_wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic [WORD_W-1:0] evt,
    input  logic              busy,
    output logic [WORD_W-1:0] status_view,
    output logic [WORD_W-1:0] mask_q,
    output logic              irq
);
    localparam int NHALF = WORD_W / HALF_W;

    logic [WORD_W-1:0] sts_q, keep, evt_impl;
    logic [NHALF-1:0]  sts_wr, msk_wr;

    assign sts_wr   = {sts_wr_hi, sts_wr_lo};
    assign msk_wr   = {msk_wr_hi, msk_wr_lo};
    assign evt_impl = evt & IMPL_MASK;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign keep[h*HALF_W +: HALF_W] = sts_wr[h] ? wdata : '1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         mask_q[h*HALF_W +: HALF_W] <= '1;
            else if (msk_wr[h]) mask_q[h*HALF_W +: HALF_W] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & keep) | evt_impl) & IMPL_MASK;
    end

    always_comb begin
        status_view           = sts_q;
        status_view[BIT_BUSY] = busy;
        irq                   = |(sts_q & ~mask_q);
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_wr_lo || sts_wr_hi) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_impl) |=> ((sts_q & $past(evt_impl)) == $past(evt_impl)));
endmodule

// File: rtl/sdh_regs.sv
module sdh_regs
    import sdh_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [31:0]       evt_flags,
    input  logic [31:0]       evt_resp,
    output logic              cmd_start,
    output logic [15:0]       cmd_word,
    output logic [31:0]       cmd_arg,
    output logic              card_clk_en,
    output logic              card_clk_slow,
    output logic [15:0]       xfer_len,
    output logic [15:0]       card_opt,
    output logic              irq
);
    logic        wr, busy, start_req, resp_end, data_end, error_evt;
    logic [15:0] cmd_q, clk_q, len_q, opt_q;
    logic [31:0] arg_q, rsp_q, status_view, mask_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wr        = bus_sel && bus_we;
    assign start_req = wr && hit(bus_addr, OFS_CMD) && !busy;
    assign resp_end  = evt_flags[BIT_RESP_END];
    assign data_end  = evt_flags[BIT_DATA_END];
    assign error_evt = |(evt_flags & ERR_BITS);

    sdh_cmd_fsm u_fsm (
        .clk, .rst_n, .start_req,
        .data_phase (cmd_q[CMD_DATA_BIT]),
        .resp_end, .data_end, .error_evt,
        .busy, .cmd_start
    );

    sdh_status_unit #(.IMPL_MASK(IMPL_BITS)) u_sts (
        .clk, .rst_n,
        .sts_wr_lo (wr && hit(bus_addr, OFS_STS)),
        .sts_wr_hi (wr && hit(bus_addr, OFS_STS + 8'd2)),
        .msk_wr_lo (wr && hit(bus_addr, OFS_MSK)),
        .msk_wr_hi (wr && hit(bus_addr, OFS_MSK + 8'd2)),
        .wdata     (bus_wdata),
        .evt       (evt_flags),
        .busy,
        .status_view, .mask_q, .irq
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0; arg_q <= '0; rsp_q <= '0;
            clk_q <= '0; len_q <= '0; opt_q <= '0;
        end else begin
            if (start_req) cmd_q <= bus_wdata;
            if (wr && hit(bus_addr, OFS_ARG))         arg_q[15:0]  <= bus_wdata;
            if (wr && hit(bus_addr, OFS_ARG + 8'd2))  arg_q[31:16] <= bus_wdata;
            if (wr && hit(bus_addr, OFS_CLKCTL) && !busy) clk_q <= bus_wdata;
            if (wr && hit(bus_addr, OFS_OPT) && !busy)    opt_q <= bus_wdata;
            if (wr && hit(bus_addr, OFS_LEN))         len_q <= bus_wdata;
            if (resp_end) rsp_q <= evt_resp;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if      (hit(bus_addr, OFS_CMD))          bus_rdata = cmd_q;
        else if (hit(bus_addr, OFS_ARG))          bus_rdata = arg_q[15:0];
        else if (hit(bus_addr, OFS_ARG + 8'd2))   bus_rdata = arg_q[31:16];
        else if (hit(bus_addr, OFS_RSP))          bus_rdata = rsp_q[15:0];
        else if (hit(bus_addr, OFS_RSP + 8'd2))   bus_rdata = rsp_q[31:16];
        else if (hit(bus_addr, OFS_STS))          bus_rdata = status_view[15:0];
        else if (hit(bus_addr, OFS_STS + 8'd2))   bus_rdata = status_view[31:16];
        else if (hit(bus_addr, OFS_MSK))          bus_rdata = mask_q[15:0];
        else if (hit(bus_addr, OFS_MSK + 8'd2))   bus_rdata = mask_q[31:16];
        else if (hit(bus_addr, OFS_CLKCTL))       bus_rdata = clk_q;
        else if (hit(bus_addr, OFS_LEN))          bus_rdata = len_q;
        else if (hit(bus_addr, OFS_OPT))          bus_rdata = opt_q;
    end

    assign cmd_word      = cmd_q;
    assign cmd_arg       = arg_q;
    assign card_clk_en   = clk_q[CLK_EN_BIT];
    assign card_clk_slow = clk_q[CLK_SLOW_BIT];
    assign xfer_len      = len_q;
    assign card_opt      = opt_q;

    assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));
    assert_clk_refuse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(clk_q) && $stable(opt_q)));
endmodule

// File: tb/sim_sdh_regs.sv
module sim_sdh_regs;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic [31:0] evt_flags = 0, evt_resp = 0;
    logic        cmd_start, card_clk_en, card_clk_slow, irq;
    logic [15:0] cmd_word, xfer_len, card_opt;
    logic [31:0] cmd_arg;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    sdh_regs u0 (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse(logic [31:0] f, logic [31:0] r);
        @(negedge clk);
        evt_flags = f; evt_resp = r;
        @(negedge clk);
        evt_flags = 0;
    endtask

    task automatic clear_all();
        wr(8'h1C, 16'h0000);
        wr(8'h1E, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(8'h1C, d); chk("R1 sts lo", d, 0);
        rd(8'h1E, d); chk("R1 sts hi", d, 0);
        rd(8'h20, d); chk("R1 mask lo", d, 16'hFFFF);
        rd(8'h22, d); chk("R1 mask hi", d, 16'hFFFF);
        rd(8'h24, d); chk("R1 clkctl", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 clk_en", card_clk_en, 0);
    endtask

    task automatic t_arg();
        logic [15:0] d;
        wr(8'h04, 16'h1234);
        wr(8'h06, 16'hABCD);
        chk("R9 cmd_arg", cmd_arg, 32'hABCD_1234);
        rd(8'h04, d); chk("R9 arg lo", d, 16'h1234);
        rd(8'h06, d); chk("R9 arg hi", d, 16'hABCD);
    endtask

    task automatic t_cmd_busy();
        logic [15:0] d;
        wr(8'h00, 16'h0611);
        chk("R2 start high", cmd_start, 1);
        chk("R2 cmd_word", cmd_word, 16'h0611);
        @(negedge clk);
        chk("R2 start one cycle", cmd_start, 0);
        rd(8'h1E, d); chk("R3 busy set", d, 16'h4000);
        wr(8'h00, 16'h0422);
        chk("R4 no restart", cmd_start, 0);
        chk("R4 word kept", cmd_word, 16'h0611);
        wr(8'h24, 16'h0140);
        wr(8'h28, 16'h80E0);
        rd(8'h24, d); chk("R11 clk refused", d, 0);
        rd(8'h28, d); chk("R11 opt refused", d, 0);
        chk("R11 clk_en off", card_clk_en, 0);
        pulse(32'h0000_0001, 32'hCAFE_0001);
        rd(8'h1E, d); chk("R3 busy clear on resp", d, 0);
        rd(8'h1C, d); chk("R5 resp end bit", d, 16'h0001);
        rd(8'h0C, d); chk("R10 rsp lo", d, 16'h0001);
        rd(8'h0E, d); chk("R10 rsp hi", d, 16'hCAFE);
        wr(8'h24, 16'h0140);
        chk("R11 clk_en", card_clk_en, 1);
        chk("R11 clk_slow", card_clk_slow, 1);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        chk("R8 masked", irq, 0);
        wr(8'h20, 16'hFFFE);
        chk("R8 unmasked", irq, 1);
        wr(8'h1C, 16'hFFFE);
        rd(8'h1C, d); chk("R6 clear bit0", d, 0);
        chk("R8 irq drops", irq, 0);
    endtask

    task automatic t_status();
        logic [15:0] d;
        pulse(32'h0102_0004, 0);
        rd(8'h1C, d); chk("R5 lo set", d, 16'h0004);
        rd(8'h1E, d); chk("R5 hi set", d, 16'h0102);
        wr(8'h1E, 16'hFEFF);
        rd(8'h1E, d); chk("R6 hi partial clear", d, 16'h0002);
        rd(8'h1C, d); chk("R6 lo untouched", d, 16'h0004);
        pulse(32'h0000_8002, 0);
        rd(8'h1C, d); chk("R5 unimplemented", d, 16'h0004);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 8'h1C; bus_wdata = 16'h0000;
        evt_flags = 32'h0000_0001;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; evt_flags = 0;
        rd(8'h1C, d); chk("R7 event wins", d, 16'h0001);
    endtask

    task automatic t_data_phase();
        logic [15:0] d;
        clear_all();
        wr(8'h00, 16'h1C11);
        pulse(32'h0000_0001, 32'h0);
        rd(8'h1E, d); chk("R3 busy through data", d, 16'h4000);
        pulse(32'h0000_0004, 32'h0);
        rd(8'h1E, d); chk("R3 busy clear on data end", d, 0);
    endtask

    task automatic t_error();
        logic [15:0] d;
        clear_all();
        wr(8'h00, 16'h0411);
        pulse(32'h0040_0000, 32'h0);
        rd(8'h1E, d); chk("R3 error aborts, R5 timeout bit", d, 16'h0040);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_arg();
        t_cmd_busy();
        t_irq();
        t_status();
        t_data_phase();
        t_error();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule